// File: doc/BRIEF.md
# Two-Way Read-Allocate Cache Controller

This block sits between a processor-side word port and a slower main-memory word port. It keeps a small two-way set-associative copy of memory blocks. Reads that find their block in the cache are answered from local storage without touching memory. Reads that miss bring the whole block in one word at a time from offset zero upward, and only then return the requested word. Writes that miss bypass the cache: they become a single memory write and no block is allocated.

A write that hits updates the cached word. What happens to memory depends on the `WRITE_BACK` parameter. With write-through (0), the same write is also sent to memory. With write-back (1), only the cached word changes and the line is flagged dirty. A dirty line chosen for replacement is written out word by word before its set's new block is fetched. Within a set the victim is the line referenced least recently. Two counters record lookup hits and misses, so the hit rate can be observed.

The processor port handles one request at a time. A request is taken while `cpu_ready` is high, and `cpu_done` pulses once when it completes. Each memory-port word moves on a valid/ready handshake.

Top module: `rcache_ctrl`

## Requirements
- R1: A read whose block is resident returns the cached word with `cpu_done`, and no memory-port transfer happens for that request.
- R2: A read miss issues exactly `LINE_WORDS` memory reads, at block offsets 0, 1, … in ascending order, before `cpu_done` returns the requested word.
- R3: A write miss performs exactly one memory write of the request's address and data and allocates nothing, so a later read of that address misses.
- R4: With `WRITE_BACK`=0, a write hit updates the cached word and issues one memory write of the same address and data.
- R5: With `WRITE_BACK`=1, a write hit updates only the cached word, leaves memory unchanged and marks the line dirty.
- R6: When a read miss selects a dirty victim, all `LINE_WORDS` words of the victim are written to memory before any fill read is issued, and memory then holds the modified data.
- R7: Each set holds two lines, and a fill replaces the line of the set that has gone longest without a hit or fill.
- R8: A word address splits into offset (low `log2(LINE_WORDS)` bits), set (next `log2(SETS)` bits) and tag (remaining high bits). Traffic in one set never disturbs the lines of another set.
- R9: A memory-port request holds `mem_valid`, `mem_we`, `mem_addr` and `mem_wdata` unchanged until `mem_ready`. One word moves in each cycle in which both are high.
- R10: `cpu_ready` is high only when the controller is idle. It is low from the cycle after a request is accepted until completion, and `cpu_done` is a one-cycle pulse.
- R11: Every lookup increments exactly one of `hit_count` (resident) and `miss_count` (not resident). Both reads and writes count.
- R12: After reset, all lines are invalid, both counters read zero and `cpu_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, taken when `cpu_ready` is high |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Controller idle and able to accept a request |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read data, valid while `cpu_done` is high for a read |
| mem_valid | output | 1 | Memory word request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ready | input | 1 | Memory accepts or returns the word this cycle |
| mem_rdata | input | DATA_W | Memory read data, sampled when `mem_valid` and `mem_ready` are high |
| hit_count | output | CNT_W | Number of lookups that hit |
| miss_count | output | CNT_W | Number of lookups that missed |

## Verification
The bench drives a write-back and a write-through instance in lockstep, each against its own memory model with a toggling ready. It goes after the recency order within a set: a wrong LRU update would evict the line just touched and turn a following hit into a four-read refill. It writes to a block and then forces that dirty line out. A controller that skipped the write-back, or fetched before writing, would leave stale memory or return wrong data when the block is refetched. It also checks that a write miss leaves no line behind and that a write hit in write-back mode leaves memory untouched. An allocating or write-through-leaking design would show an unexpected hit or an unexpected memory write.

// File: rtl/rcache_pkg.sv
package rcache_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_EVICT,
    ST_FILL,
    ST_THRU,
    ST_REPLY
  } ctl_state_t;

  // the other way of a two-way set
  function automatic logic other_way(input logic w);
    return ~w;
  endfunction

endpackage

// File: rtl/rcache_tagcmp.sv
module rcache_tagcmp #(
  parameter int TAG_W = 6
) (
  input  logic [1:0]         way_vld,
  input  logic [2*TAG_W-1:0] way_tags,
  input  logic [TAG_W-1:0]   req_tag,
  output logic               hit,
  output logic               hit_way,
  output logic               both_match
);
  logic [1:0] match;

  for (genvar w = 0; w < 2; w++) begin : g_way
    assign match[w] = way_vld[w] && (way_tags[w*TAG_W +: TAG_W] == req_tag);
  end

  assign hit        = |match;
  assign hit_way    = match[1];
  assign both_match = &match;
endmodule

// File: rtl/rcache_lru.sv
module rcache_lru #(
  parameter int SETS  = 4,
  parameter int SET_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch,
  input  logic [SET_W-1:0] touch_set,
  input  logic             touch_way,
  input  logic [SET_W-1:0] look_set,
  output logic             victim
);
  import rcache_pkg::*;

  // per set: the way that was referenced least recently
  logic [SETS-1:0] lru_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lru_q <= '0;
    else if (touch) lru_q[touch_set] <= other_way(touch_way);
  end

  assign victim = lru_q[look_set];

  assert_lru_track_R7: assert property (@(posedge clk) disable iff (!rst_n)
    touch |=> lru_q[$past(touch_set)] != $past(touch_way));
endmodule

// File: rtl/rcache_stats.sv
module rcache_stats #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_ev,
  input  logic             miss_ev,
  output logic [CNT_W-1:0] hits,
  output logic [CNT_W-1:0] misses
);
  localparam logic [CNT_W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hits   <= '0;
      misses <= '0;
    end else begin
      if (hit_ev && hits != TOP)     hits   <= hits + 1'b1;
      if (miss_ev && misses != TOP)  misses <= misses + 1'b1;
    end
  end

  assert_excl_events_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_ev && miss_ev));
endmodule

// File: rtl/rcache_ctrl.sv
module rcache_ctrl #(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 16,
  parameter int LINE_WORDS = 4,
  parameter int SETS       = 4,
  parameter int CNT_W      = 16,
  parameter bit WRITE_BACK = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_valid,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);
  import rcache_pkg::*;

  localparam int OFF_W   = $clog2(LINE_WORDS);
  localparam int SET_W   = $clog2(SETS);
  localparam int TAG_W   = ADDR_W - SET_W - OFF_W;
  localparam int LINE_W  = SET_W + 1;
  localparam int WORD_W  = LINE_W + OFF_W;
  localparam int ENTRIES = 1 << LINE_W;
  localparam int WORDS   = 1 << WORD_W;
  localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(LINE_WORDS - 1);

  // address field helpers
  function automatic logic [TAG_W-1:0] f_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction
  function automatic logic [SET_W-1:0] f_set(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: SET_W];
  endfunction
  function automatic logic [OFF_W-1:0] f_off(input logic [ADDR_W-1:0] a);
    return a[OFF_W-1:0];
  endfunction
  function automatic logic [LINE_W-1:0] f_line(input logic w, input logic [SET_W-1:0] s);
    return {w, s};
  endfunction
  function automatic logic [WORD_W-1:0] f_word(input logic w, input logic [SET_W-1:0] s,
                                                input logic [OFF_W-1:0] o);
    return {w, s, o};
  endfunction

  // state
  ctl_state_t        state;
  logic              rq_we;
  logic [ADDR_W-1:0] rq_addr;
  logic [DATA_W-1:0] rq_wdata;
  logic              vic_way;
  logic [OFF_W-1:0]  beat;
  logic              done_q;
  logic [DATA_W-1:0] rdata_q;

  logic [TAG_W-1:0]  tag_q  [ENTRIES];
  logic [ENTRIES-1:0] vld_q;
  logic [ENTRIES-1:0] dty_q;
  logic [DATA_W-1:0] data_q [WORDS];

  // request fields
  logic [TAG_W-1:0] rq_tag;
  logic [SET_W-1:0] rq_set;
  logic [OFF_W-1:0] rq_off;
  assign rq_tag = f_tag(rq_addr);
  assign rq_set = f_set(rq_addr);
  assign rq_off = f_off(rq_addr);

  // lookup
  logic hit, hit_way, both_match, victim;
  logic [2*TAG_W-1:0] way_tags;
  logic [1:0]         way_vld;
  assign way_tags = {tag_q[f_line(1'b1, rq_set)], tag_q[f_line(1'b0, rq_set)]};
  assign way_vld  = {vld_q[f_line(1'b1, rq_set)], vld_q[f_line(1'b0, rq_set)]};

  rcache_tagcmp #(.TAG_W(TAG_W)) u_tagcmp (
    .way_vld    (way_vld),
    .way_tags   (way_tags),
    .req_tag    (rq_tag),
    .hit        (hit),
    .hit_way    (hit_way),
    .both_match (both_match)
  );

  // named internal events
  logic lookup, ev_rd_hit, ev_wr_hit, ev_rd_miss, ev_wr_miss;
  logic xfer, beat_last, ev_wb_last, ev_fill_last, vic_dirty;
  logic touch, touch_way;

  assign lookup       = (state == ST_LOOK);
  assign ev_rd_hit    = lookup &&  hit && !rq_we;
  assign ev_wr_hit    = lookup &&  hit &&  rq_we;
  assign ev_rd_miss   = lookup && !hit && !rq_we;
  assign ev_wr_miss   = lookup && !hit &&  rq_we;
  assign xfer         = mem_valid && mem_ready;
  assign beat_last    = (beat == LAST_BEAT);
  assign ev_wb_last   = (state == ST_EVICT) && xfer && beat_last;
  assign ev_fill_last = (state == ST_FILL)  && xfer && beat_last;
  assign vic_dirty    = vld_q[f_line(victim, rq_set)] && dty_q[f_line(victim, rq_set)];
  assign touch        = ev_rd_hit || ev_wr_hit || ev_fill_last;
  assign touch_way    = lookup ? hit_way : vic_way;

  rcache_lru #(.SETS(SETS), .SET_W(SET_W)) u_lru (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch     (touch),
    .touch_set (rq_set),
    .touch_way (touch_way),
    .look_set  (rq_set),
    .victim    (victim)
  );

  rcache_stats #(.CNT_W(CNT_W)) u_stats (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit_ev  (lookup && hit),
    .miss_ev (lookup && !hit),
    .hits    (hit_count),
    .misses  (miss_count)
  );

  // memory port
  always_comb begin
    mem_valid = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (state)
      ST_EVICT: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {tag_q[f_line(vic_way, rq_set)], rq_set, beat};
        mem_wdata = data_q[f_word(vic_way, rq_set, beat)];
      end
      ST_FILL: begin
        mem_valid = 1'b1;
        mem_addr  = {rq_tag, rq_set, beat};
      end
      ST_THRU: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = rq_addr;
        mem_wdata = rq_wdata;
      end
      default: ;
    endcase
  end

  // control and line state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      rq_we    <= 1'b0;
      rq_addr  <= '0;
      rq_wdata <= '0;
      vic_way  <= 1'b0;
      beat     <= '0;
      done_q   <= 1'b0;
      rdata_q  <= '0;
      vld_q    <= '0;
      dty_q    <= '0;
      for (int i = 0; i < ENTRIES; i++) tag_q[i] <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: if (cpu_req) begin
          rq_we    <= cpu_we;
          rq_addr  <= cpu_addr;
          rq_wdata <= cpu_wdata;
          state    <= ST_LOOK;
        end
        ST_LOOK: begin
          if (ev_rd_hit) begin
            rdata_q <= data_q[f_word(hit_way, rq_set, rq_off)];
            done_q  <= 1'b1;
            state   <= ST_IDLE;
          end else if (ev_wr_hit) begin
            if (WRITE_BACK) begin
              dty_q[f_line(hit_way, rq_set)] <= 1'b1;
              done_q <= 1'b1;
              state  <= ST_IDLE;
            end else begin
              state <= ST_THRU;
            end
          end else if (ev_wr_miss) begin
            state <= ST_THRU;
          end else begin
            vic_way <= victim;
            beat    <= '0;
            if (vic_dirty) begin
              state <= ST_EVICT;
            end else begin
              vld_q[f_line(victim, rq_set)] <= 1'b0;
              state <= ST_FILL;
            end
          end
        end
        ST_EVICT: if (xfer) begin
          beat <= beat + 1'b1;
          if (beat_last) begin
            dty_q[f_line(vic_way, rq_set)] <= 1'b0;
            vld_q[f_line(vic_way, rq_set)] <= 1'b0;
            state <= ST_FILL;
          end
        end
        ST_FILL: if (xfer) begin
          beat <= beat + 1'b1;
          if (beat_last) begin
            tag_q[f_line(vic_way, rq_set)] <= rq_tag;
            vld_q[f_line(vic_way, rq_set)] <= 1'b1;
            dty_q[f_line(vic_way, rq_set)] <= 1'b0;
            state <= ST_REPLY;
          end
        end
        ST_REPLY: begin
          rdata_q <= data_q[f_word(vic_way, rq_set, rq_off)];
          done_q  <= 1'b1;
          state   <= ST_IDLE;
        end
        ST_THRU: if (xfer) begin
          done_q <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // word storage, no reset
  always_ff @(posedge clk) begin
    if (ev_wr_hit)
      data_q[f_word(hit_way, rq_set, rq_off)] <= rq_wdata;
    if (state == ST_FILL && xfer)
      data_q[f_word(vic_way, rq_set, beat)] <= mem_rdata;
  end

  assign cpu_ready = (state == ST_IDLE);
  assign cpu_done  = done_q;
  assign cpu_rdata = rdata_q;

  // checks beside the logic
  assert_rdhit_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rd_hit |=> !mem_valid && cpu_done);

  assert_fill_then_reply_R2: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_REPLY |-> $past(state) == ST_FILL);

  assert_wrmiss_noalloc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_miss |=> state == ST_THRU && $stable(vld_q));

  assert_thru_on_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wr_hit && !WRITE_BACK) |=> state == ST_THRU);

  assert_wb_local_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wr_hit && WRITE_BACK) |=> !mem_valid && cpu_done && $stable(vld_q));

  assert_evict_before_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FILL && $past(state) == ST_EVICT) |-> $past(ev_wb_last));

  assert_one_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !both_match);

  assert_mem_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> mem_valid && $stable(mem_addr) && $stable(mem_we)
                                  && $stable(mem_wdata));

  assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !cpu_ready);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);
endmodule

// File: tb/rcache_ctrl_tb.sv
module rcache_ctrl_tb;
  localparam int AW = 10;
  localparam int DW = 16;
  localparam int MW = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int vecs = 0;
  int fails = 0;

  logic          req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;

  // a: write-back instance, b: write-through instance
  logic rdy_a, done_a, mv_a, mwe_a, mrdy_a;
  logic rdy_b, done_b, mv_b, mwe_b, mrdy_b;
  logic [DW-1:0] rd_a, mwd_a, mrd_a, rd_b, mwd_b, mrd_b;
  logic [AW-1:0] maddr_a, maddr_b;
  logic [15:0]   hits_a, miss_a, hits_b, miss_b;

  rcache_ctrl #(.ADDR_W(AW), .DATA_W(DW), .WRITE_BACK(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(req), .cpu_we(we), .cpu_addr(addr),
    .cpu_wdata(wdata), .cpu_ready(rdy_a), .cpu_done(done_a), .cpu_rdata(rd_a),
    .mem_valid(mv_a), .mem_we(mwe_a), .mem_addr(maddr_a), .mem_wdata(mwd_a),
    .mem_ready(mrdy_a), .mem_rdata(mrd_a), .hit_count(hits_a), .miss_count(miss_a));

  rcache_ctrl #(.ADDR_W(AW), .DATA_W(DW), .WRITE_BACK(1'b0)) u_wt (
    .clk(clk), .rst_n(rst_n), .cpu_req(req), .cpu_we(we), .cpu_addr(addr),
    .cpu_wdata(wdata), .cpu_ready(rdy_b), .cpu_done(done_b), .cpu_rdata(rd_b),
    .mem_valid(mv_b), .mem_we(mwe_b), .mem_addr(maddr_b), .mem_wdata(mwd_b),
    .mem_ready(mrdy_b), .mem_rdata(mrd_b), .hit_count(hits_b), .miss_count(miss_b));

  // memory models with toggling ready
  logic [DW-1:0] mem_a [MW];
  logic [DW-1:0] mem_b [MW];
  logic [DW-1:0] arch  [MW];
  logic [AW-1:0] rlog [4];
  int nrd_a = 0, nwr_a = 0, nrd_b = 0, nwr_b = 0;

  assign mrd_a = mem_a[maddr_a];
  assign mrd_b = mem_b[maddr_b];

  always @(posedge clk) begin
    if (!rst_n) begin
      mrdy_a <= 1'b0;
      mrdy_b <= 1'b1;
    end else begin
      mrdy_a <= ~mrdy_a;
      mrdy_b <= ~mrdy_b;
      if (mv_a && mrdy_a) begin
        if (mwe_a) begin mem_a[maddr_a] <= mwd_a; nwr_a <= nwr_a + 1; end
        else begin
          nrd_a <= nrd_a + 1;
          rlog[0] <= rlog[1]; rlog[1] <= rlog[2]; rlog[2] <= rlog[3]; rlog[3] <= maddr_a;
        end
      end
      if (mv_b && mrdy_b) begin
        if (mwe_b) begin mem_b[maddr_b] <= mwd_b; nwr_b <= nwr_b + 1; end
        else nrd_b <= nrd_b + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard
  logic [DW-1:0] exp_a[$];
  logic [DW-1:0] exp_b[$];
  int got_a = 0, got_b = 0;
  bit pend_rd = 1'b0;
  string pend_tag = "";

  always @(negedge clk) begin
    if (rst_n && done_a) begin
      if (pend_rd) begin
        if (exp_a.size() == 0) chk(1'b0, {pend_tag, " R10 extra done (wb)"}, 1, 0);
        else begin
          chk(rd_a == exp_a[0], {pend_tag, " rdata (wb)"}, int'(rd_a), int'(exp_a[0]));
          void'(exp_a.pop_front());
        end
      end
      got_a = got_a + 1;
    end
    if (rst_n && done_b) begin
      if (pend_rd) begin
        if (exp_b.size() == 0) chk(1'b0, {pend_tag, " R10 extra done (wt)"}, 1, 0);
        else begin
          chk(rd_b == exp_b[0], {pend_tag, " rdata (wt)"}, int'(rd_b), int'(exp_b[0]));
          void'(exp_b.pop_front());
        end
      end
      got_b = got_b + 1;
    end
  end

  // per-operation memory traffic deltas
  int dra, dwa, drb, dwb;

  task automatic op(input bit w, input int a, input int d, input bit exp_hit, input string tag);
    int ca, cb, ha, ma, hb, mb, ra, wa, rb, wb;
    ca = got_a; cb = got_b;
    ha = int'(hits_a); ma = int'(miss_a); hb = int'(hits_b); mb = int'(miss_b);
    ra = nrd_a; wa = nwr_a; rb = nrd_b; wb = nwr_b;
    @(negedge clk);
    req = 1'b1; we = w; addr = AW'(a); wdata = DW'(d);
    pend_rd = !w; pend_tag = tag;
    if (!w) begin exp_a.push_back(arch[a]); exp_b.push_back(arch[a]); end
    else arch[a] = DW'(d);
    @(negedge clk);
    req = 1'b0;
    chk(!rdy_a && !rdy_b, {tag, " R10 ready low while busy"}, int'({rdy_a, rdy_b}), 0);
    wait (got_a > ca && got_b > cb);
    @(negedge clk);
    chk(int'(hits_a) - ha == int'(exp_hit) && int'(miss_a) - ma == int'(!exp_hit),
        {tag, " R11 counters (wb)"}, int'(hits_a) - ha, int'(exp_hit));
    chk(int'(hits_b) - hb == int'(exp_hit) && int'(miss_b) - mb == int'(!exp_hit),
        {tag, " R11 counters (wt)"}, int'(hits_b) - hb, int'(exp_hit));
    dra = nrd_a - ra; dwa = nwr_a - wa; drb = nrd_b - rb; dwb = nwr_b - wb;
  endtask

  function automatic int mk(input int t, input int s, input int o);
    return t * 16 + s * 4 + o;
  endfunction

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog: run did not complete actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    int e_addr, w_addr;
    logic [DW-1:0] e_old;
    for (int i = 0; i < MW; i++) begin
      mem_a[i] = DW'(i * 7 + 3);
      mem_b[i] = DW'(i * 7 + 3);
      arch[i]  = DW'(i * 7 + 3);
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rdy_a && rdy_b, "R12 ready after reset", int'({rdy_a, rdy_b}), 3);
    chk(hits_a == 0 && miss_a == 0 && hits_b == 0 && miss_b == 0, "R12 counters zero",
        int'(hits_a + miss_a + hits_b + miss_b), 0);

    // R2 / R9: first read misses and fills the block in order
    op(1'b0, mk(1, 0, 2), 0, 1'b0, "R2 read miss");
    chk(dra == 4 && drb == 4, "R2 R9 fill beats", dra, 4);
    chk(rlog[0] == AW'(mk(1, 0, 0)) && rlog[3] == AW'(mk(1, 0, 3)), "R2 fill order",
        int'(rlog[0]), mk(1, 0, 0));

    // R1: hit in the same block
    op(1'b0, mk(1, 0, 3), 0, 1'b1, "R1 read hit");
    chk(dra == 0 && drb == 0, "R1 no memory traffic", dra + drb, 0);

    // R7: recency order in set 0
    op(1'b0, mk(2, 0, 0), 0, 1'b0, "R7 second line");
    op(1'b0, mk(1, 0, 1), 0, 1'b1, "R7 touch first line");
    op(1'b0, mk(3, 0, 1), 0, 1'b0, "R7 third line evicts LRU");
    op(1'b0, mk(1, 0, 0), 0, 1'b1, "R7 recent line kept");
    chk(dra == 0, "R7 kept line no refill", dra, 0);
    op(1'b0, mk(2, 0, 3), 0, 1'b0, "R7 evicted line misses");
    chk(dra == 4, "R7 evicted line refilled", dra, 4);

    // R3: write miss bypasses
    w_addr = mk(5, 2, 1);
    op(1'b1, w_addr, 'hBEEF, 1'b0, "R3 write miss");
    chk(dwa == 1 && dra == 0 && dwb == 1 && drb == 0, "R3 single memory write", dwa, 1);
    chk(mem_a[w_addr] == 16'hBEEF && mem_b[w_addr] == 16'hBEEF, "R3 memory updated",
        int'(mem_a[w_addr]), 'hBEEF);
    op(1'b0, w_addr, 0, 1'b0, "R3 no allocation");
    chk(dra == 4, "R3 read after write miss refills", dra, 4);

    // R4 / R5: write hit under both policies
    e_addr = mk(1, 1, 2);
    e_old  = mem_a[e_addr];
    op(1'b0, e_addr, 0, 1'b0, "R8 fill set 1");
    op(1'b1, e_addr, 'h1234, 1'b1, "R5 write hit");
    chk(dwa == 0 && mem_a[e_addr] == e_old, "R5 memory untouched (wb)",
        int'(mem_a[e_addr]), int'(e_old));
    chk(dwb == 1 && mem_b[e_addr] == 16'h1234, "R4 memory written (wt)",
        int'(mem_b[e_addr]), 'h1234);
    op(1'b0, e_addr, 0, 1'b1, "R4 R5 cached word updated");

    // R6: dirty line forced out
    op(1'b0, mk(2, 1, 0), 0, 1'b0, "R6 second line in set 1");
    op(1'b0, mk(3, 1, 0), 0, 1'b0, "R6 dirty victim");
    chk(dwa == 4 && dra == 4, "R6 write-back beats then fill", dwa, 4);
    chk(mem_a[e_addr] == 16'h1234, "R6 memory holds modified word",
        int'(mem_a[e_addr]), 'h1234);
    chk(dwb == 0, "R4 clean victim not written (wt)", dwb, 0);
    op(1'b0, e_addr, 0, 1'b0, "R6 refetch after write-back");

    // R8: other sets left set 0 intact
    op(1'b0, mk(1, 0, 2), 0, 1'b1, "R8 set 0 lines untouched");
    chk(dra == 0 && drb == 0, "R8 no refill in set 0", dra + drb, 0);

    repeat (2) @(negedge clk);
    chk(exp_a.size() == 0 && exp_b.size() == 0, "R10 every read answered",
        exp_a.size() + exp_b.size(), 0);
    summary();
    $finish;
  end
endmodule